// File: doc/BRIEF.md
# Two-Pass 2-D Haar Transform with Transposing Store

This block computes one level of the separable 2-D Haar transform over a square image of N×N unsigned pixels. Pixels arrive in raster order (row by row, left to right) on a valid/ready stream. A single 1-D Haar stage turns each row into pairwise floor-averages and differences. Each of these coefficients is written into an on-chip N×N store at a transposed address, so a column of the row-pass result lands in one contiguous stretch of memory.

Once the whole row pass has been stored, an internal fetch sequencer reads the store at linear addresses. This delivers the columns of the row-pass result one after another. A second 1-D Haar stage transforms them, and the block emits the final coefficients tagged with their row and column indices. A one-cycle done pulse follows the last coefficient. A new image is accepted only after the block is idle again.

The store is one bit wider than a pixel, because it has to hold signed row differences. The output is one bit wider again.

Top module: `haar2d_xpose`

## Requirements
- R1: While reset is held and right after it, `busy`, `pix_ready`, `coef_valid` and `done` are all 0.
- R2: After an accepted `start`, `pix_ready` is high until exactly N×N pixels have been accepted (a pixel is accepted on a cycle with `pix_valid` and `pix_ready` both high). It then falls and stays low until the next image. `pix_ready` is never high while `busy` is low.
- R3: The row pass maps each input pair a = x[r][2i], b = x[r][2i+1] to floor((a+b)/2) at row position i and to a−b at row position N/2+i.
- R4: Each output coefficient at (row u, column k) is the same pair rule applied down column k of the row-pass result: it uses rows 2i and 2i+1, places the average at u=i and the difference at u=N/2+i, and the difference is top minus bottom.
- R5: Coefficients come out column by column, with k running from 0 to N−1. Within a column the row order is 0, N/2, 1, N/2+1, …, N/2−1, N−1. `coef_col` carries k and `coef_row` carries u. Each difference is emitted on the cycle right after its average.
- R6: Coefficients are exact two's-complement values of PIX_W+2 bits, including images with full-scale pixel swings.
- R7: No coefficient is emitted before all N×N pixels of the image have been accepted. The store is never written and read in the same cycle.
- R8: `done` is high for exactly one cycle, on the cycle after the coefficient at row N−1, column N−1. That pulse happens once per image.
- R9: A `start` pulse while `busy` is high is ignored: the image being processed still yields exactly N×N correct coefficients and one done pulse.
- R10: Input gaps, meaning cycles with `pix_valid` low during loading, do not change any coefficient.
- R11: The design works for any power-of-two N ≥ 4, including N=8 and N=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new image; honoured only when idle |
| busy | output | 1 | High from accepted start until done |
| pix_valid | input | 1 | Pixel on `pix_data` is valid |
| pix_data | input | PIX_W | Unsigned pixel, raster order |
| pix_ready | output | 1 | Block can accept a pixel this cycle |
| coef_valid | output | 1 | Coefficient output is valid |
| coef_data | output | PIX_W+2 | Signed 2-D Haar coefficient |
| coef_row | output | log2(N) | Row index u of the coefficient |
| coef_col | output | log2(N) | Column index k of the coefficient |
| done | output | 1 | One-cycle pulse after the last coefficient |

## Verification
The assertions check the following on every cycle: each difference follows its average with the paired index, no output overlaps loading, the store is never written and read at once, the fetch addresses advance one step at a time, `pix_ready` stays within busy, and done is a single cycle that follows the final coefficient. The bench scenarios are needed for the arithmetic itself: they compare every coefficient against a separable model computed in the bench. They run random, ramp, row-constant and full-scale checkerboard images at N=8 and N=16. They also show that input gaps and a stray start during loading leave the results untouched.

// File: rtl/haar2d_pkg.sv
package haar2d_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_FLUSH,
    PH_FETCH,
    PH_DRAIN
  } phase_t;
endpackage

// File: rtl/haar_pair_stage.sv
module haar_pair_stage #(
  parameter int N         = 8,
  parameter int IN_W      = 8,
  parameter int IN_SIGNED = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  output logic                     out_valid,
  output logic [$clog2(N)-1:0]     out_pos,
  output logic [$clog2(N)-1:0]     out_vec,
  output logic signed [IN_W:0]     out_data
);
  localparam int LG    = $clog2(N);
  localparam int OUT_W = IN_W + 1;
  localparam logic [LG-1:0] HALF = LG'(N / 2);
  localparam logic [LG-1:0] LAST = LG'(N - 1);

  function automatic logic signed [OUT_W-1:0] widen(input logic [IN_W-1:0] v);
    logic ext;
    ext = (IN_SIGNED != 0) ? v[IN_W-1] : 1'b0;
    return {ext, v};
  endfunction

  function automatic logic signed [OUT_W-1:0] pair_avg(input logic signed [OUT_W-1:0] a,
                                                       input logic signed [OUT_W-1:0] b);
    logic signed [OUT_W:0] s;
    s = {a[OUT_W-1], a} + {b[OUT_W-1], b};
    return s[OUT_W:1];
  endfunction

  function automatic logic signed [OUT_W-1:0] pair_dif(input logic signed [OUT_W-1:0] a,
                                                       input logic signed [OUT_W-1:0] b);
    return a - b;
  endfunction

  logic [LG-1:0]            pos_q, vec_q, pend_pos_q, pend_vec_q;
  logic signed [OUT_W-1:0]  even_q, pend_data_q, cur_w;
  logic                     pend_q;
  logic                     odd_in;

  assign odd_in = in_valid && pos_q[0];
  assign cur_w  = widen(in_data);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos_q       <= '0;
      vec_q       <= '0;
      pend_q      <= 1'b0;
      out_valid   <= 1'b0;
      out_pos     <= '0;
      out_vec     <= '0;
      out_data    <= '0;
      even_q      <= '0;
      pend_pos_q  <= '0;
      pend_vec_q  <= '0;
      pend_data_q <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        pos_q <= pos_q + 1'b1;
        if (pos_q == LAST) vec_q <= vec_q + 1'b1;
        if (!pos_q[0]) even_q <= cur_w;
      end
      if (odd_in) begin
        out_valid   <= 1'b1;
        out_pos     <= pos_q >> 1;
        out_vec     <= vec_q;
        out_data    <= pair_avg(even_q, cur_w);
        pend_q      <= 1'b1;
        pend_pos_q  <= (pos_q >> 1) + HALF;
        pend_vec_q  <= vec_q;
        pend_data_q <= pair_dif(even_q, cur_w);
      end else if (pend_q) begin
        out_valid <= 1'b1;
        out_pos   <= pend_pos_q;
        out_vec   <= pend_vec_q;
        out_data  <= pend_data_q;
        pend_q    <= 1'b0;
      end
    end
  end

  AST_DIFF_FOLLOWS_AVG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pos[LG-1] && !clear) |=>
      (out_valid && out_pos == $past(out_pos) + HALF && out_vec == $past(out_vec))); // R5
endmodule

// File: rtl/xpose_store.sv
module xpose_store #(
  parameter int N     = 8,
  parameter int DAT_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(N)-1:0]      wr_pos,
  input  logic [$clog2(N)-1:0]      wr_vec,
  input  logic [DAT_W-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [2*$clog2(N)-1:0]    rd_addr,
  output logic [DAT_W-1:0]          rd_data
);
  localparam int LG    = $clog2(N);
  localparam int DEPTH = N * N;

  logic [DAT_W-1:0] mem [DEPTH];
  logic [2*LG-1:0]  wr_addr;

  // coefficient at row-pass vector r, position c lands at c*N + r
  assign wr_addr = {wr_pos, wr_vec};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R7
endmodule

// File: rtl/rd_fetch.sv
module rd_fetch #(
  parameter int N = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  output logic                    rd_req,
  output logic [2*$clog2(N)-1:0]  rd_addr,
  output logic                    rd_last
);
  localparam int AW = 2 * $clog2(N);
  localparam logic [AW-1:0] TOP = AW'(N * N - 1);

  assign rd_req  = en;
  assign rd_last = en && (rd_addr == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) rd_addr <= '0;
    else               rd_addr <= rd_addr + 1'b1;
  end

  AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_last) |=> (rd_req && rd_addr == $past(rd_addr) + 1'b1)); // R4
endmodule

// File: rtl/haar2d_xpose.sv
module haar2d_xpose #(
  parameter int N     = 8,
  parameter int PIX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  input  logic                        pix_valid,
  input  logic [PIX_W-1:0]            pix_data,
  output logic                        pix_ready,
  output logic                        coef_valid,
  output logic signed [PIX_W+1:0]     coef_data,
  output logic [$clog2(N)-1:0]        coef_row,
  output logic [$clog2(N)-1:0]        coef_col,
  output logic                        done
);
  import haar2d_pkg::*;

  localparam int LG    = $clog2(N);
  localparam int AW    = 2 * LG;
  localparam int MEM_W = PIX_W + 1;
  localparam logic [LG-1:0] LAST = LG'(N - 1);
  localparam logic [AW-1:0] TOP  = AW'(N * N - 1);

  phase_t phase_q;
  logic [AW-1:0] pix_cnt_q;
  logic          accept, last_pix, start_ok;

  logic                     s1_valid;
  logic [LG-1:0]            s1_pos, s1_vec;
  logic signed [MEM_W-1:0]  s1_data;
  logic                     p1_last_wr;

  logic                     rd_req, rd_last, rd_vld_q;
  logic [AW-1:0]            rd_addr;
  logic [MEM_W-1:0]         rd_data;
  logic                     p2_last;

  assign start_ok  = start && (phase_q == PH_IDLE);
  assign pix_ready = (phase_q == PH_LOAD);
  assign busy      = (phase_q != PH_IDLE);
  assign accept    = pix_valid && pix_ready;
  assign last_pix  = accept && (pix_cnt_q == TOP);
  assign p1_last_wr = s1_valid && (s1_pos == LAST) && (s1_vec == LAST);
  assign p2_last    = coef_valid && (coef_row == LAST) && (coef_col == LAST);

  haar_pair_stage #(.N(N), .IN_W(PIX_W), .IN_SIGNED(0)) u_row (
    .clk(clk), .rst_n(rst_n), .clear(start_ok),
    .in_valid(accept), .in_data(pix_data),
    .out_valid(s1_valid), .out_pos(s1_pos), .out_vec(s1_vec), .out_data(s1_data)
  );

  xpose_store #(.N(N), .DAT_W(MEM_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(s1_valid), .wr_pos(s1_pos), .wr_vec(s1_vec), .wr_data(s1_data),
    .rd_en(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rd_fetch #(.N(N)) u_fetch (
    .clk(clk), .rst_n(rst_n), .en(phase_q == PH_FETCH),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_last(rd_last)
  );

  haar_pair_stage #(.N(N), .IN_W(MEM_W), .IN_SIGNED(1)) u_col (
    .clk(clk), .rst_n(rst_n), .clear(start_ok),
    .in_valid(rd_vld_q), .in_data(rd_data),
    .out_valid(coef_valid), .out_pos(coef_row), .out_vec(coef_col), .out_data(coef_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      pix_cnt_q <= '0;
      rd_vld_q  <= 1'b0;
      done      <= 1'b0;
    end else begin
      rd_vld_q <= rd_req;
      done     <= p2_last;
      if (accept) pix_cnt_q <= pix_cnt_q + 1'b1;
      unique case (phase_q)
        PH_IDLE:  if (start_ok) begin
                    phase_q   <= PH_LOAD;
                    pix_cnt_q <= '0;
                  end
        PH_LOAD:  if (last_pix)   phase_q <= PH_FLUSH;
        PH_FLUSH: if (p1_last_wr) phase_q <= PH_FETCH;
        PH_FETCH: if (rd_last)    phase_q <= PH_DRAIN;
        PH_DRAIN: if (p2_last)    phase_q <= PH_IDLE;
        default:                  phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_READY_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy); // R2
  AST_NO_OUT_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !coef_valid); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(coef_valid && coef_row == LAST && coef_col == LAST)); // R8
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !p2_last) |=> busy); // R9
endmodule

// File: tb/sim_haar2d_xpose.sv
module sim_haar2d_xpose;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  logic pix_valid = 1'b0;
  logic [W-1:0] pix_data = '0;

  logic b0_busy, b0_ready, b0_cv, b0_done;
  logic signed [W+1:0] b0_cd;
  logic [2:0] b0_row, b0_col;
  logic b1_busy, b1_ready, b1_cv, b1_done;
  logic signed [W+1:0] b1_cd;
  logic [3:0] b1_row, b1_col;

  haar2d_xpose #(.N(8), .PIX_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .busy(b0_busy),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(b0_ready),
    .coef_valid(b0_cv), .coef_data(b0_cd), .coef_row(b0_row), .coef_col(b0_col),
    .done(b0_done));

  haar2d_xpose #(.N(16), .PIX_W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .busy(b1_busy),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(b1_ready),
    .coef_valid(b1_cv), .coef_data(b1_cd), .coef_row(b1_row), .coef_col(b1_col),
    .done(b1_done));

  logic sel = 1'b0;
  int   cur_n;
  logic c_busy, c_ready, c_cv, c_done;
  logic signed [W+1:0] c_cd;
  logic [3:0] c_row, c_col;
  always_comb begin
    cur_n   = sel ? 16 : 8;
    c_busy  = sel ? b1_busy  : b0_busy;
    c_ready = sel ? b1_ready : b0_ready;
    c_cv    = sel ? b1_cv    : b0_cv;
    c_done  = sel ? b1_done  : b0_done;
    c_cd    = sel ? b1_cd    : b0_cd;
    c_row   = sel ? b1_row   : {1'b0, b0_row};
    c_col   = sel ? b1_col   : {1'b0, b0_col};
  end

  int checks = 0, fails = 0;
  int img [256];
  int got [256];
  int expv[256];
  int out_cnt, order_err, early_out, done_cnt, done_err;
  logic loading = 1'b0, prev_last = 1'b0, mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int floor_half(input int s);
    return (s >= 0) ? s / 2 : -((1 - s) / 2);
  endfunction

  // monitor: order, completeness, done timing
  always @(negedge clk) begin
    if (mon_on) begin
      if (c_done) begin
        done_cnt++;
        if (!prev_last) done_err++;
      end
      prev_last = 1'b0;
      if (c_cv) begin
        int k, m, er;
        k  = out_cnt / cur_n;
        m  = out_cnt % cur_n;
        er = (m % 2 == 0) ? m / 2 : cur_n / 2 + m / 2;
        if (int'(c_row) != er || int'(c_col) != k) order_err++;
        if (loading) early_out++;
        got[int'(c_row) * cur_n + int'(c_col)] = int'(c_cd);
        prev_last = (int'(c_row) == cur_n - 1) && (int'(c_col) == cur_n - 1);
        out_cnt++;
      end
    end
  end

  task automatic build_expected(input int n);
    int rowp[256];
    for (int r = 0; r < n; r++)
      for (int i = 0; i < n / 2; i++) begin
        int a, b;
        a = img[r * n + 2 * i];
        b = img[r * n + 2 * i + 1];
        rowp[r * n + i]         = floor_half(a + b);
        rowp[r * n + n / 2 + i] = a - b;
      end
    for (int k = 0; k < n; k++)
      for (int i = 0; i < n / 2; i++) begin
        int a, b;
        a = rowp[(2 * i) * n + k];
        b = rowp[(2 * i + 1) * n + k];
        expv[i * n + k]         = floor_half(a + b);
        expv[(n / 2 + i) * n + k] = a - b;
      end
  endtask

  // mode: 0 random, 1 ramp, 2 full-scale checker, 3 rows identical
  task automatic run_image(input int n, input int mode, input bit gaps, input bit poke,
                           input string vtag);
    int p, bad, first_bad_a, first_bad_e, wait_cyc;
    sel = (n == 16);
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) begin
        case (mode)
          0: img[r * n + c] = int'($urandom % 256);
          1: img[r * n + c] = (r * 17 + c * 5) % 256;
          2: img[r * n + c] = ((r + c) % 2 == 0) ? 255 : 0;
          default: img[r * n + c] = (r == 0) ? int'($urandom % 256) : img[c];
        endcase
      end
    build_expected(n);
    out_cnt = 0; order_err = 0; early_out = 0; done_cnt = 0; done_err = 0;
    for (int i = 0; i < 256; i++) got[i] = 99999;
    @(negedge clk);
    if (sel) start1 = 1'b1; else start0 = 1'b1;
    loading = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    p = 0;
    while (p < n * n) begin
      start0 = 1'b0; start1 = 1'b0;
      if (poke && p == 5) begin
        if (sel) start1 = 1'b1; else start0 = 1'b1;
      end
      if (gaps && ($urandom % 4 == 0)) begin
        pix_valid = 1'b0;
      end else if (c_ready) begin
        pix_valid = 1'b1;
        pix_data  = W'(img[p]);
        p++;
      end else begin
        pix_valid = 1'b0;
      end
      @(negedge clk);
    end
    pix_valid = 1'b0; start0 = 1'b0; start1 = 1'b0;
    chk(!c_ready, "R2 ready falls after N*N pixels", int'(c_ready), 0);
    loading = 1'b0;
    wait_cyc = 0;
    while (done_cnt == 0 && wait_cyc < 4000) begin
      @(negedge clk);
      wait_cyc++;
    end
    repeat (3) @(negedge clk);
    bad = 0; first_bad_a = 0; first_bad_e = 0;
    for (int i = 0; i < n * n; i++)
      if (got[i] != expv[i]) begin
        if (bad == 0) begin first_bad_a = got[i]; first_bad_e = expv[i]; end
        bad++;
      end
    chk(bad == 0, vtag, first_bad_a, first_bad_e);
    chk(order_err == 0 && out_cnt == n * n, "R5 emission order and count", out_cnt, n * n);
    chk(early_out == 0, "R7 no output during loading", early_out, 0);
    chk(done_cnt == 1 && done_err == 0, "R8 single done after last coef", done_cnt, 1);
    chk(!c_busy, "R2 busy low after done", int'(c_busy), 0);
    if (mode == 3) begin
      bad = 0;
      for (int i = 0; i < n / 2; i++) begin
        if (got[i] != floor_half(img[2 * i] + img[2 * i + 1])) bad++;
        if (got[n / 2 + i] != img[2 * i] - img[2 * i + 1]) bad++;
      end
      chk(bad == 0, "R3 row pass on row-constant image", bad, 0);
    end
    if (poke)
      chk(out_cnt == n * n && done_cnt == 1 && bad == 0, "R9 start while busy ignored",
          out_cnt, n * n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!b0_busy && !b0_ready && !b0_cv && !b0_done, "R1 reset outputs N=8",
        int'({b0_busy, b0_ready, b0_cv, b0_done}), 0);
    chk(!b1_busy && !b1_ready && !b1_cv && !b1_done, "R1 reset outputs N=16",
        int'({b1_busy, b1_ready, b1_cv, b1_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!b0_busy && !b0_ready && !b1_busy && !b1_ready, "R1 idle after reset",
        int'({b0_busy, b0_ready, b1_busy, b1_ready}), 0);
    mon_on = 1'b1;
    run_image(8, 0, 1'b0, 1'b0, "R4 random 8x8 coefficients");
    run_image(8, 1, 1'b0, 1'b0, "R4 ramp 8x8 coefficients");
    run_image(8, 2, 1'b0, 1'b0, "R6 full-scale checker 8x8");
    run_image(8, 3, 1'b0, 1'b0, "R4 row-constant 8x8");
    run_image(8, 0, 1'b1, 1'b0, "R10 random 8x8 with input gaps");
    run_image(8, 0, 1'b0, 1'b1, "R9 random 8x8 with stray start");
    for (int t = 0; t < 3; t++)
      run_image(16, 0, t[0], 1'b0, "R11 random 16x16 coefficients");
    run_image(16, 2, 1'b0, 1'b0, "R6 full-scale checker 16x16");
    run_image(16, 3, 1'b1, 1'b1, "R11 row-constant 16x16 gaps and stray start");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule